// File: doc/BRIEF.md
# Receive Buffer Match and Store Engine

This block decides where a freshly received frame goes. A frame that passes both the syntax check and the semantic check is presented for one clock with its frame ID, its cycle count and the channel it came in on. The engine compares that frame against a bank of receive buffer filters. The lowest-indexed buffer that matches on every field wins, and the search starts just above the region of buffers lent to the receive FIFO. When no buffer matches, a single FIFO filter is tried. If that filter also misses, the frame is dropped. Payload movement is not modelled here: the block only pulses a store strobe with a buffer index, or a FIFO write strobe, one cycle after it decides.

Each buffer keeps a full flag and a small lock state machine. Every buffer runs its own machine with the states `BS_IDLE`, `BS_LOCKED`, `BS_HELD` and `BS_FLUSH`. The transitions are:

- lock grant: `BS_IDLE` to `BS_LOCKED`.
- unlock with nothing held: `BS_LOCKED` to `BS_IDLE`.
- match while locked: `BS_LOCKED` to `BS_HELD`.
- unlock with a held frame: `BS_HELD` to `BS_FLUSH`, or `BS_LOCKED` to `BS_FLUSH` when a match arrives in the same cycle as the unlock.
- deferred write done, or a direct write lands: `BS_FLUSH` to `BS_IDLE`.

A frame that matches a locked buffer is therefore deferred and written once the host lets go. A second match while a frame is already held replaces the held frame and raises frame-lost. The full flags, each gated by its own enable bit, are OR-ed into one interrupt line. A vector output names the lowest flagged buffer.

Top module: `rxm_engine`

## Requirements
- R1: A frame is considered only when `frm_valid`, `frm_syn_ok` and `frm_sem_ok` are all 1. Any other frame causes no store, no FIFO write, no frame-lost pulse and no flag change.
- R2: A buffer matches when all of the following hold: its ID equals `frm_id`; `frm_cyc` equals its cycle value on every bit where its cycle mask is 1; and its 2-bit channel-select has the bit for the frame's channel set (bit 0 = channel A, bit 1 = channel B, so 0 disables the buffer). Of all matching eligible buffers, the lowest index is chosen.
- R3: Buffers with an index below `cfg_fifo_len` belong to the FIFO and are never selected. With `cfg_fifo_len` = 0 the search starts at buffer 0.
- R4: With no buffer match, `fifo_we` pulses the cycle after the frame if `cfg_fifo_len` is nonzero and the FIFO filter matches. The FIFO filter matches on `frm_id` under `cfg_fifo_id_mask` (1 = compared) and on the channel-select bit. Otherwise the frame is discarded with no output.
- R5: A match to an unlocked buffer gives `store_we` = 1 and `store_idx` = that buffer in the cycle after the frame, and sets its full flag. This also happens when the flag is already set, and then no frame-lost is raised.
- R6: A lock request for an idle buffer that is not being written that cycle makes its `lock_ack` bit read 1 in the next cycle. An unlock request clears `lock_ack` in the next cycle.
- R7: A match to a locked buffer produces no store and leaves its full flag unchanged. After the unlock request, `store_we` for that buffer appears in the second cycle and the full flag is set.
- R8: A further match to a buffer whose frame is still held pulses `frame_lost` with `lost_idx` set to that buffer in the next cycle. The later unlock produces exactly one store.
- R9: Writing 1 to a bit of `host_flag_clr` clears that full flag in the next cycle. A store to the same buffer in the same cycle wins, and the flag stays set.
- R10: `irq` is 1 when any full flag with its `cfg_irq_en` bit set is 1. `irq_vec` gives the lowest such index, and `irq_vec_valid` follows `irq`.
- R11: The store port carries at most one write per cycle. A direct frame write takes precedence over a deferred write, which then follows in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_valid | input | 1 | Received frame present this cycle |
| frm_syn_ok | input | 1 | Frame passed syntax checks |
| frm_sem_ok | input | 1 | Frame passed semantic checks |
| frm_id | input | IDW | Frame ID |
| frm_cyc | input | CYW | Cycle count the frame arrived in |
| frm_chan_b | input | 1 | 0 = channel A, 1 = channel B |
| cfg_fifo_len | input | IXW+1 | Number of low buffers lent to the FIFO |
| cfg_fifo_id | input | IDW | FIFO filter ID value |
| cfg_fifo_id_mask | input | IDW | FIFO filter ID mask, 1 = compared |
| cfg_fifo_chsel | input | 2 | FIFO channel select |
| cfg_id | input | NBUF*IDW | Per-buffer filter ID |
| cfg_cyc | input | NBUF*CYW | Per-buffer cycle value |
| cfg_cyc_mask | input | NBUF*CYW | Per-buffer cycle mask, 1 = compared |
| cfg_chsel | input | NBUF*2 | Per-buffer channel select |
| cfg_irq_en | input | NBUF | Per-buffer interrupt enable |
| host_lock_req | input | 1 | Lock request for `host_idx` |
| host_unlock_req | input | 1 | Unlock request for `host_idx` |
| host_idx | input | IXW | Buffer addressed by lock or unlock |
| host_flag_clr | input | NBUF | Write-one-to-clear full flags |
| lock_ack | output | NBUF | Lock held per buffer |
| full_flag | output | NBUF | Full flag per buffer |
| irq | output | 1 | OR of enabled full flags |
| irq_vec_valid | output | 1 | `irq_vec` is meaningful |
| irq_vec | output | IXW | Lowest enabled flagged buffer |
| store_we | output | 1 | Buffer payload write strobe |
| store_idx | output | IXW | Buffer being written |
| fifo_we | output | 1 | FIFO write strobe |
| frame_lost | output | 1 | A held frame was replaced |
| lost_idx | output | IXW | Buffer that lost a frame |

## Verification
The bench goes after the following corner cases:

- Priority between overlapping filters: a wider filter placed above a narrower one. A design that scanned from the top, or ignored the cycle mask, would report a different `store_idx`.
- Channel masking.
- FIFO boundary moves: a buffer below `cfg_fifo_len` must stop winning. A design without the region check would keep storing into FIFO buffers.
- FIFO fallback versus drop when no FIFO is configured.
- The lock sequence, including a double match while locked. A design that wrote through a lock, forgot the held frame at unlock, or flushed twice would show a stray or missing strobe, or no `frame_lost`.
- A frame arriving in the same cycle as a pending deferred write. This exposes a store port that drops one of the two writes.
- A flag clear colliding with a new store.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    // Per-buffer lock / deferral state
    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_LOCKED = 2'd1,
        BS_HELD   = 2'd2,
        BS_FLUSH  = 2'd3
    } buf_state_e;

endpackage

// File: rtl/rxm_first_set.sv
module rxm_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/rxm_filter_match.sv
module rxm_filter_match #(
    parameter int IDW = 11,
    parameter int CYW = 6
) (
    input  logic [IDW-1:0] frm_id,
    input  logic [CYW-1:0] frm_cyc,
    input  logic           frm_chan_b,
    input  logic [IDW-1:0] flt_id,
    input  logic [CYW-1:0] flt_cyc,
    input  logic [CYW-1:0] flt_cyc_mask,
    input  logic [1:0]     flt_chsel,
    output logic           hit
);

    logic id_eq;
    logic cyc_eq;
    logic chan_ok;

    always_comb begin
        id_eq   = (frm_id == flt_id);
        cyc_eq  = (((frm_cyc ^ flt_cyc) & flt_cyc_mask) == '0);
        chan_ok = frm_chan_b ? flt_chsel[1] : flt_chsel[0];
        hit     = id_eq && cyc_eq && chan_ok;
    end

endmodule

// File: rtl/rxm_buf_ctl.sv
module rxm_buf_ctl
    import rxm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic grant_i,
    input  logic lock_req_i,
    input  logic unlock_req_i,
    input  logic flag_clr_i,
    output logic direct_o,
    output logic write_o,
    output logic lost_o,
    output logic flush_req_o,
    output logic locked_o,
    output logic full_o
);

    buf_state_e st;
    buf_state_e st_nx;
    logic       want_q;
    logic       full_q;
    logic       lock_go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= BS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            BS_IDLE: begin
                if (lock_go) st_nx = BS_LOCKED;
            end
            BS_LOCKED: begin
                if (unlock_req_i && hit_i) st_nx = BS_FLUSH;
                else if (unlock_req_i)     st_nx = BS_IDLE;
                else if (hit_i)            st_nx = BS_HELD;
            end
            BS_HELD: begin
                if (unlock_req_i) st_nx = BS_FLUSH;
            end
            BS_FLUSH: begin
                if (hit_i || grant_i) st_nx = BS_IDLE;
            end
            default: st_nx = BS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lock_go     = (lock_req_i || want_q) && (st == BS_IDLE) && !hit_i && !unlock_req_i;
        direct_o    = hit_i && ((st == BS_IDLE) || (st == BS_FLUSH));
        write_o     = direct_o || grant_i;
        lost_o      = hit_i && ((st == BS_HELD) || (st == BS_FLUSH));
        flush_req_o = (st == BS_FLUSH);
        locked_o    = (st == BS_LOCKED) || (st == BS_HELD);
        full_o      = full_q;
    end

    // Pending lock request and full flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (unlock_req_i || lock_go) begin
                want_q <= 1'b0;
            end else if (lock_req_i && ((st == BS_IDLE) || (st == BS_FLUSH))) begin
                want_q <= 1'b1;
            end
            if (write_o) begin
                full_q <= 1'b1;
            end else if (flag_clr_i) begin
                full_q <= 1'b0;
            end
        end
    end

    p_lock_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req_i && st == BS_IDLE && !hit_i && !unlock_req_i) |=> locked_o);

    p_hold_on_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BS_LOCKED && hit_i && !unlock_req_i) |=> (st == BS_HELD && !write_o));

    p_held_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BS_HELD && hit_i && !unlock_req_i) |=> (st == BS_HELD));

    p_full_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        write_o |=> full_o);

endmodule

// File: rtl/rxm_engine.sv
module rxm_engine #(
    parameter int NBUF = 8,
    parameter int IDW  = 11,
    parameter int CYW  = 6,
    localparam int IXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic                 frm_syn_ok,
    input  logic                 frm_sem_ok,
    input  logic [IDW-1:0]       frm_id,
    input  logic [CYW-1:0]       frm_cyc,
    input  logic                 frm_chan_b,
    input  logic [IXW:0]         cfg_fifo_len,
    input  logic [IDW-1:0]       cfg_fifo_id,
    input  logic [IDW-1:0]       cfg_fifo_id_mask,
    input  logic [1:0]           cfg_fifo_chsel,
    input  logic [NBUF*IDW-1:0]  cfg_id,
    input  logic [NBUF*CYW-1:0]  cfg_cyc,
    input  logic [NBUF*CYW-1:0]  cfg_cyc_mask,
    input  logic [NBUF*2-1:0]    cfg_chsel,
    input  logic [NBUF-1:0]      cfg_irq_en,
    input  logic                 host_lock_req,
    input  logic                 host_unlock_req,
    input  logic [IXW-1:0]       host_idx,
    input  logic [NBUF-1:0]      host_flag_clr,
    output logic [NBUF-1:0]      lock_ack,
    output logic [NBUF-1:0]      full_flag,
    output logic                 irq,
    output logic                 irq_vec_valid,
    output logic [IXW-1:0]       irq_vec,
    output logic                 store_we,
    output logic [IXW-1:0]       store_idx,
    output logic                 fifo_we,
    output logic                 frame_lost,
    output logic [IXW-1:0]       lost_idx
);

    logic            frm_accept;
    logic [NBUF-1:0] raw_hit;
    logic [NBUF-1:0] cand;
    logic [NBUF-1:0] hit_vec;
    logic [NBUF-1:0] direct_vec;
    logic [NBUF-1:0] write_vec;
    logic [NBUF-1:0] lost_vec;
    logic [NBUF-1:0] flush_vec;
    logic [NBUF-1:0] grant_vec;
    logic [NBUF-1:0] irq_src;
    logic            sel_found;
    logic [IXW-1:0]  sel_idx;
    logic            fl_found;
    logic [IXW-1:0]  fl_idx;
    logic            fifo_hit;
    logic            fifo_take;

    assign frm_accept = frm_valid && frm_syn_ok && frm_sem_ok;

    // Filter bank with FIFO-region exclusion
    for (genvar i = 0; i < NBUF; i++) begin : g_flt
        rxm_filter_match #(.IDW(IDW), .CYW(CYW)) i_match (
            .frm_id       (frm_id),
            .frm_cyc      (frm_cyc),
            .frm_chan_b   (frm_chan_b),
            .flt_id       (cfg_id[i*IDW +: IDW]),
            .flt_cyc      (cfg_cyc[i*CYW +: CYW]),
            .flt_cyc_mask (cfg_cyc_mask[i*CYW +: CYW]),
            .flt_chsel    (cfg_chsel[i*2 +: 2]),
            .hit          (raw_hit[i])
        );
        assign cand[i] = raw_hit[i] && ((IXW+1)'(i) >= cfg_fifo_len);
    end

    rxm_first_set #(.N(NBUF), .IW(IXW)) i_pick_match (
        .vec   (cand),
        .found (sel_found),
        .idx   (sel_idx)
    );

    // Per-buffer lock machines
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        assign hit_vec[i] = frm_accept && sel_found && (sel_idx == IXW'(i));
        rxm_buf_ctl i_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .hit_i        (hit_vec[i]),
            .grant_i      (grant_vec[i]),
            .lock_req_i   (host_lock_req && (host_idx == IXW'(i))),
            .unlock_req_i (host_unlock_req && (host_idx == IXW'(i))),
            .flag_clr_i   (host_flag_clr[i]),
            .direct_o     (direct_vec[i]),
            .write_o      (write_vec[i]),
            .lost_o       (lost_vec[i]),
            .flush_req_o  (flush_vec[i]),
            .locked_o     (lock_ack[i]),
            .full_o       (full_flag[i])
        );
        assign grant_vec[i] = fl_found && (fl_idx == IXW'(i)) && !(|direct_vec);
    end

    // Deferred-write arbitration: lowest pending buffer
    rxm_first_set #(.N(NBUF), .IW(IXW)) i_pick_flush (
        .vec   (flush_vec),
        .found (fl_found),
        .idx   (fl_idx)
    );

    // Interrupt vector
    assign irq_src = full_flag & cfg_irq_en;
    assign irq     = |irq_src;

    rxm_first_set #(.N(NBUF), .IW(IXW)) i_pick_irq (
        .vec   (irq_src),
        .found (irq_vec_valid),
        .idx   (irq_vec)
    );

    // FIFO fallback
    always_comb begin
        fifo_hit  = (cfg_fifo_len != '0)
                 && (((frm_id ^ cfg_fifo_id) & cfg_fifo_id_mask) == '0)
                 && (frm_chan_b ? cfg_fifo_chsel[1] : cfg_fifo_chsel[0]);
        fifo_take = frm_accept && !sel_found && fifo_hit;
    end

    // Registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_we   <= 1'b0;
            store_idx  <= '0;
            fifo_we    <= 1'b0;
            frame_lost <= 1'b0;
            lost_idx   <= '0;
        end else begin
            store_we   <= |write_vec;
            store_idx  <= (|direct_vec) ? sel_idx : fl_idx;
            fifo_we    <= fifo_take;
            frame_lost <= |lost_vec;
            lost_idx   <= sel_idx;
        end
    end

    p_one_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(write_vec) && !((|direct_vec) && (|grant_vec)));

    p_invalid_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !(frm_syn_ok && frm_sem_ok)) |=> (!fifo_we && !frame_lost));

    p_vec_flagged_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec_valid |-> (full_flag[irq_vec] && cfg_irq_en[irq_vec]));

    p_irq_matches_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == irq_vec_valid);

    p_store_outside_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|direct_vec) |-> ({1'b0, sel_idx} >= cfg_fifo_len));

endmodule

// File: tb/test_rxm_engine.sv
`timescale 1ns/1ps
module test_rxm_engine;

    localparam int NBUF = 8;
    localparam int IDW  = 11;
    localparam int CYW  = 6;
    localparam int IXW  = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                frm_valid = 1'b0, frm_syn_ok = 1'b0, frm_sem_ok = 1'b0;
    logic [IDW-1:0]      frm_id = '0;
    logic [CYW-1:0]      frm_cyc = '0;
    logic                frm_chan_b = 1'b0;
    logic [IXW:0]        cfg_fifo_len = '0;
    logic [IDW-1:0]      cfg_fifo_id = 11'd16;
    logic [IDW-1:0]      cfg_fifo_id_mask = 11'h7F0;
    logic [1:0]          cfg_fifo_chsel = 2'b11;
    logic [NBUF*IDW-1:0] cfg_id;
    logic [NBUF*CYW-1:0] cfg_cyc;
    logic [NBUF*CYW-1:0] cfg_cyc_mask;
    logic [NBUF*2-1:0]   cfg_chsel;
    logic [NBUF-1:0]     cfg_irq_en = '0;
    logic                host_lock_req = 1'b0, host_unlock_req = 1'b0;
    logic [IXW-1:0]      host_idx = '0;
    logic [NBUF-1:0]     host_flag_clr = '0;
    logic [NBUF-1:0]     lock_ack, full_flag;
    logic                irq, irq_vec_valid, store_we, fifo_we, frame_lost;
    logic [IXW-1:0]      irq_vec, store_idx, lost_idx;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    // Filter set: id, cycle value, cycle mask, channel select
    initial begin
        cfg_id = '0; cfg_cyc = '0; cfg_cyc_mask = '0; cfg_chsel = '0;
        cfg_id[0*IDW +: IDW] = 11'd5;  cfg_chsel[0*2 +: 2] = 2'b11;
        cfg_id[1*IDW +: IDW] = 11'd5;  cfg_cyc[1*CYW +: CYW] = 6'd2;
        cfg_cyc_mask[1*CYW +: CYW] = 6'd3; cfg_chsel[1*2 +: 2] = 2'b01;
        cfg_id[2*IDW +: IDW] = 11'd7;  cfg_chsel[2*2 +: 2] = 2'b10;
        cfg_id[3*IDW +: IDW] = 11'd5;  cfg_chsel[3*2 +: 2] = 2'b11;
        cfg_id[4*IDW +: IDW] = 11'd9;  cfg_chsel[4*2 +: 2] = 2'b11;
        cfg_id[5*IDW +: IDW] = 11'd9;  cfg_cyc[5*CYW +: CYW] = 6'd1;
        cfg_cyc_mask[5*CYW +: CYW] = 6'd1; cfg_chsel[5*2 +: 2] = 2'b11;
        cfg_id[6*IDW +: IDW] = 11'd12; cfg_chsel[6*2 +: 2] = 2'b11;
        cfg_id[7*IDW +: IDW] = 11'd0;  cfg_chsel[7*2 +: 2] = 2'b00;
    end

    rxm_engine #(.NBUF(NBUF), .IDW(IDW), .CYW(CYW)) i_rxm_engine (
        .clk(clk), .rst_n(rst_n),
        .frm_valid(frm_valid), .frm_syn_ok(frm_syn_ok), .frm_sem_ok(frm_sem_ok),
        .frm_id(frm_id), .frm_cyc(frm_cyc), .frm_chan_b(frm_chan_b),
        .cfg_fifo_len(cfg_fifo_len), .cfg_fifo_id(cfg_fifo_id),
        .cfg_fifo_id_mask(cfg_fifo_id_mask), .cfg_fifo_chsel(cfg_fifo_chsel),
        .cfg_id(cfg_id), .cfg_cyc(cfg_cyc), .cfg_cyc_mask(cfg_cyc_mask),
        .cfg_chsel(cfg_chsel), .cfg_irq_en(cfg_irq_en),
        .host_lock_req(host_lock_req), .host_unlock_req(host_unlock_req),
        .host_idx(host_idx), .host_flag_clr(host_flag_clr),
        .lock_ack(lock_ack), .full_flag(full_flag), .irq(irq),
        .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec),
        .store_we(store_we), .store_idx(store_idx), .fifo_we(fifo_we),
        .frame_lost(frame_lost), .lost_idx(lost_idx)
    );

    typedef struct packed {
        logic       syn;
        logic       sem;
        logic [10:0] id;
        logic [5:0] cyc;
        logic       chb;
        logic [3:0] flen;
        logic       ewe;
        logic [2:0] eidx;
        logic       efifo;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b1, 1'b1, 11'd5,  6'd0, 1'b0, 4'd0, 1'b1, 3'd0, 1'b0}, // R2 lowest wins
        '{1'b1, 1'b1, 11'd5,  6'd6, 1'b0, 4'd1, 1'b1, 3'd1, 1'b0}, // R3 skip buf0, cycle mask
        '{1'b1, 1'b1, 11'd5,  6'd6, 1'b1, 4'd1, 1'b1, 3'd3, 1'b0}, // R2 channel B
        '{1'b1, 1'b1, 11'd5,  6'd3, 1'b0, 4'd1, 1'b1, 3'd3, 1'b0}, // R2 cycle miss
        '{1'b1, 1'b1, 11'd5,  6'd6, 1'b0, 4'd2, 1'b1, 3'd3, 1'b0}, // R3 region grows
        '{1'b1, 1'b1, 11'd7,  6'd0, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0}, // R4 drop
        '{1'b1, 1'b1, 11'd7,  6'd0, 1'b1, 4'd0, 1'b1, 3'd2, 1'b0}, // R2 B only
        '{1'b1, 1'b1, 11'd20, 6'd0, 1'b0, 4'd2, 1'b0, 3'd0, 1'b1}, // R4 fifo
        '{1'b1, 1'b1, 11'd20, 6'd0, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0}, // R4 no fifo
        '{1'b1, 1'b1, 11'd9,  6'd1, 1'b0, 4'd0, 1'b1, 3'd4, 1'b0}, // R2
        '{1'b1, 1'b1, 11'd9,  6'd3, 1'b0, 4'd5, 1'b1, 3'd5, 1'b0}, // R3
        '{1'b1, 1'b1, 11'd9,  6'd2, 1'b0, 4'd5, 1'b0, 3'd0, 1'b0}, // R4 drop
        '{1'b0, 1'b1, 11'd5,  6'd0, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0}, // R1 syntax bad
        '{1'b1, 1'b0, 11'd20, 6'd0, 1'b0, 4'd2, 1'b0, 3'd0, 1'b0}, // R1 semantic bad
        '{1'b1, 1'b1, 11'd0,  6'd0, 1'b0, 4'd0, 1'b0, 3'd0, 1'b0}, // R2 disabled buf
        '{1'b1, 1'b1, 11'd12, 6'd0, 1'b0, 4'd7, 1'b0, 3'd0, 1'b0}, // R3 excluded
        '{1'b1, 1'b1, 11'd31, 6'd0, 1'b1, 4'd7, 1'b0, 3'd0, 1'b1}  // R4 fifo B
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one frame for one cycle; returns at the negedge after the decision edge
    task automatic send(input logic syn, input logic sem, input int id,
                        input int cyc, input logic chb);
        frm_valid = 1'b1; frm_syn_ok = syn; frm_sem_ok = sem;
        frm_id = IDW'(id); frm_cyc = CYW'(cyc); frm_chan_b = chb;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic host(input logic lk, input logic ul, input int idx);
        host_lock_req = lk; host_unlock_req = ul; host_idx = IXW'(idx);
        @(negedge clk);
        host_lock_req = 1'b0; host_unlock_req = 1'b0;
    endtask

    task automatic clr_all();
        host_flag_clr = '1;
        @(negedge clk);
        host_flag_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R5 reset store_we", int'(store_we), 0);
        chk("R10 reset irq", int'(irq), 0);
        chk("R6 reset lock_ack", int'(lock_ack), 0);
        chk("R5 reset full_flag", int'(full_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [NBUF-1:0] fprev;
            fprev = full_flag;
            cfg_fifo_len = TBL[v].flen;
            send(TBL[v].syn, TBL[v].sem, int'(TBL[v].id), int'(TBL[v].cyc), TBL[v].chb);
            chk($sformatf("R2/R3 vec%0d store_we", v), int'(store_we), int'(TBL[v].ewe));
            if (TBL[v].ewe)
                chk($sformatf("R2/R3 vec%0d store_idx", v), int'(store_idx), int'(TBL[v].eidx));
            chk($sformatf("R4 vec%0d fifo_we", v), int'(fifo_we), int'(TBL[v].efifo));
            chk($sformatf("R1 vec%0d frame_lost", v), int'(frame_lost), 0);
            if (!TBL[v].ewe)
                chk($sformatf("R1 vec%0d flags unchanged", v), int'(full_flag), int'(fprev));
        end
        @(negedge clk);
        clr_all();
        chk("R9 flags cleared", int'(full_flag), 0);

        // R5 overwrite of a full buffer
        cfg_fifo_len = '0;
        send(1'b1, 1'b1, 5, 0, 1'b0);
        send(1'b1, 1'b1, 5, 0, 1'b0);
        chk("R5 overwrite store_we", int'(store_we), 1);
        chk("R5 overwrite idx", int'(store_idx), 0);
        chk("R5 overwrite no lost", int'(frame_lost), 0);
        chk("R5 full set", int'(full_flag[0]), 1);

        // R9 clear and set-wins collision
        host_flag_clr = 8'h01;
        @(negedge clk);
        host_flag_clr = '0;
        chk("R9 clear", int'(full_flag[0]), 0);
        host_flag_clr = 8'h01;
        send(1'b1, 1'b1, 5, 0, 1'b0);
        host_flag_clr = '0;
        chk("R9 set wins", int'(full_flag[0]), 1);
        clr_all();

        // R6/R7/R8 lock, hold, double match, unlock
        cfg_fifo_len = 4'd1;
        host(1'b1, 1'b0, 3);
        chk("R6 lock_ack after request", int'(lock_ack[3]), 1);
        send(1'b1, 1'b1, 5, 0, 1'b1);
        chk("R7 no store while locked", int'(store_we), 0);
        chk("R7 flag untouched", int'(full_flag[3]), 0);
        chk("R8 first hold no lost", int'(frame_lost), 0);
        send(1'b1, 1'b1, 5, 0, 1'b1);
        chk("R8 frame_lost", int'(frame_lost), 1);
        chk("R8 lost_idx", int'(lost_idx), 3);
        chk("R7 still no store", int'(store_we), 0);
        host(1'b0, 1'b1, 3);
        chk("R6 ack cleared", int'(lock_ack[3]), 0);
        chk("R7 not yet stored", int'(store_we), 0);
        @(negedge clk);
        chk("R7 deferred store_we", int'(store_we), 1);
        chk("R7 deferred idx", int'(store_idx), 3);
        chk("R7 full after flush", int'(full_flag[3]), 1);
        @(negedge clk);
        chk("R8 single flush", int'(store_we), 0);
        clr_all();

        // R11 direct write beats pending flush
        cfg_fifo_len = '0;
        host(1'b1, 1'b0, 4);
        send(1'b1, 1'b1, 9, 0, 1'b0);
        chk("R7 buf4 held", int'(store_we), 0);
        host(1'b0, 1'b1, 4);
        send(1'b1, 1'b1, 5, 0, 1'b0);
        chk("R11 frame first", int'(store_idx), 0);
        chk("R11 frame store_we", int'(store_we), 1);
        @(negedge clk);
        chk("R11 flush after", int'(store_we), 1);
        chk("R11 flush idx", int'(store_idx), 4);
        clr_all();

        // R10 interrupt gating and vector
        cfg_irq_en = 8'b0010_1000;
        @(negedge clk);
        chk("R10 irq idle", int'(irq), 0);
        cfg_fifo_len = 4'd5;
        send(1'b1, 1'b1, 9, 1, 1'b0);
        chk("R10 irq on buf5", int'(irq), 1);
        chk("R10 vec 5", int'(irq_vec), 5);
        cfg_fifo_len = 4'd1;
        send(1'b1, 1'b1, 5, 0, 1'b1);
        chk("R10 vec 3", int'(irq_vec), 3);
        cfg_fifo_len = '0;
        send(1'b1, 1'b1, 5, 0, 1'b0);
        chk("R10 masked buf0", int'(irq_vec), 3);
        host_flag_clr = 8'h08;
        @(negedge clk);
        host_flag_clr = '0;
        chk("R10 vec back to 5", int'(irq_vec), 5);
        chk("R10 vec valid", int'(irq_vec_valid), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule